// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block sits beside the register file of a small 8-bit processor core. It turns a decoded load, store, code-fetch or indirect-jump request into an effective address. Three 16-bit pointers are supplied as byte pairs from the working registers: pointer 0, pointer 1 and pointer 2. Each request names a pointer, an addressing mode and a 6-bit unsigned displacement. The block answers with the address to drive on the selected memory space. For the auto-modify modes it also returns the new pointer value, which the register file must write back.

Requests and responses both use a valid/ready handshake. A request transfers on a rising edge when `req_valid` and `req_ready` are both high. Its response appears on the next cycle through a single output register. `req_ready` is high whenever that register is empty or is being drained in the same cycle, so back-to-back requests run at one per cycle. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and `req_ready` stays low. The pointer byte inputs are sampled only in the cycle in which the request transfers.

Top module: `ptr_addr_gen`

## Requirements
- R1: Mode code 0 (plain indirect) returns the selected pointer as the address, with write-back disabled.
- R2: Mode code 1 (displacement) returns pointer + zero-extended displacement, modulo 2^16, for pointer 1 or 2. With pointer 0 the displacement is ignored and the address is the pointer itself. Write-back is disabled.
- R3: Mode code 2 (pre-decrement) returns pointer − 1, modulo 2^16, both as the address and as the write-back value.
- R4: Mode code 3 (post-increment) returns the unmodified pointer as the address and pointer + 1, modulo 2^16, as the write-back value.
- R5: `rsp_wb_en` is 1 only for mode codes 2 and 3. `rsp_wb_sel` names the pointer that was used: 0, 1 or 2.
- R6: Mode code 4 (code-memory load) always uses pointer 2, whatever `req_sel` says. It sets `rsp_code` and `rsp_to_r0` and clears `rsp_jump`.
- R7: Mode code 5 (indirect jump or call) always uses pointer 2 as the target address. It sets `rsp_jump` and clears `rsp_code` and `rsp_to_r0`.
- R8: A response appears one cycle after its request transfers. While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values and `req_ready` is low. `req_ready` equals `!rsp_valid || rsp_ready`.
- R9: While `rst_n` is low, and after reset with no requests, `rsp_valid` is 0 and `req_ready` is 1.
- R10: A pointer value is {high byte, low byte}; for example, high byte 0x12 and low byte 0x34 give 0x1234.
- R11: Mode codes 6 and 7 behave as mode code 0. Select code 3 selects pointer 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_sel | input | 2 | Pointer select (0, 1, 2; 3 acts as 2) |
| req_disp | input | DISP_W (6) | Unsigned displacement |
| x_lo | input | REG_W (8) | Pointer 0 low byte |
| x_hi | input | REG_W (8) | Pointer 0 high byte |
| y_lo | input | REG_W (8) | Pointer 1 low byte |
| y_hi | input | REG_W (8) | Pointer 1 high byte |
| z_lo | input | REG_W (8) | Pointer 2 low byte |
| z_hi | input | REG_W (8) | Pointer 2 high byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 2*REG_W (16) | Effective address |
| rsp_wb_en | output | 1 | Pointer write-back required |
| rsp_wb_sel | output | 2 | Pointer that was used |
| rsp_wb_val | output | 2*REG_W (16) | Updated pointer value |
| rsp_code | output | 1 | Address targets code memory |
| rsp_jump | output | 1 | Address is a jump target |
| rsp_to_r0 | output | 1 | Loaded byte goes to register 0 |

## Verification
The checker watches every transfer on each cycle. It checks that the response appears one cycle later and holds under back-pressure, and that pre-decrement returns the same value as address and write-back. It checks that post-increment returns a write-back one above the address, and that write-back stays off in every other mode. It also checks that code loads and jumps carry the pointer 2 value and the right flags. Only the bench scenarios can show the exact arithmetic against fixed pointer values: wrap at 0x0000 and 0xFFFF, the displacement being ignored on pointer 0, the reserved codes, and byte ordering. The same holds for ordered delivery of a long stream under an irregular ready pattern.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_DISP    = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_POSTINC = 3'd3,
    AM_CODE    = 3'd4,
    AM_JUMP    = 3'd5
  } amode_e;

  localparam logic [1:0] PSEL_X = 2'd0;
  localparam logic [1:0] PSEL_Y = 2'd1;
  localparam logic [1:0] PSEL_Z = 2'd2;
  localparam int unsigned NUM_PTR = 3;

  function automatic logic forces_z(input logic [2:0] m);
    return (m == AM_CODE) || (m == AM_JUMP);
  endfunction
endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux
  import dag_pkg::*;
#(
  parameter int REG_W = 8,
  localparam int AW = 2 * REG_W
) (
  input  logic [NUM_PTR-1:0][AW-1:0] ptrs,
  input  logic [1:0]                 sel,
  input  logic [2:0]                 mode,
  output logic [AW-1:0]              ptr,
  output logic [1:0]                 eff_sel
);
  always_comb begin
    if (forces_z(mode) || sel == 2'd3) eff_sel = PSEL_Z;
    else                               eff_sel = sel;
    case (eff_sel)
      PSEL_X:  ptr = ptrs[0];
      PSEL_Y:  ptr = ptrs[1];
      default: ptr = ptrs[2];
    endcase
  end
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
  import dag_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int DISP_W = 6,
  localparam int AW = 2 * REG_W
) (
  input  logic [2:0]        mode,
  input  logic [AW-1:0]     ptr,
  input  logic [1:0]        eff_sel,
  input  logic [DISP_W-1:0] disp,
  output logic [AW-1:0]     addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val,
  output logic              code,
  output logic              jump,
  output logic              to_r0
);
  logic [AW-1:0] dec_v, inc_v, off_v;

  assign dec_v = ptr - AW'(1);
  assign inc_v = ptr + AW'(1);
  assign off_v = (eff_sel == PSEL_X) ? ptr : ptr + AW'(disp);

  always_comb begin
    addr   = ptr;
    wb_en  = 1'b0;
    wb_val = ptr;
    code   = 1'b0;
    jump   = 1'b0;
    to_r0  = 1'b0;
    case (mode)
      AM_DISP:    addr = off_v;
      AM_PREDEC:  begin addr = dec_v; wb_val = dec_v; wb_en = 1'b1; end
      AM_POSTINC: begin wb_val = inc_v; wb_en = 1'b1; end
      AM_CODE:    begin code = 1'b1; to_r0 = 1'b1; end
      AM_JUMP:    jump = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/dag_rsp_stage.sv
module dag_rsp_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import dag_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int DISP_W = 6,
  localparam int AW = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [1:0]        req_sel,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [REG_W-1:0]  x_lo,
  input  logic [REG_W-1:0]  x_hi,
  input  logic [REG_W-1:0]  y_lo,
  input  logic [REG_W-1:0]  y_hi,
  input  logic [REG_W-1:0]  z_lo,
  input  logic [REG_W-1:0]  z_hi,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_addr,
  output logic              rsp_wb_en,
  output logic [1:0]        rsp_wb_sel,
  output logic [AW-1:0]     rsp_wb_val,
  output logic              rsp_code,
  output logic              rsp_jump,
  output logic              rsp_to_r0
);
  localparam int PKT_W = 2 * AW + 6;

  logic [NUM_PTR-1:0][REG_W-1:0] lo_b, hi_b;
  logic [NUM_PTR-1:0][AW-1:0]    ptrs;

  assign lo_b = {z_lo, y_lo, x_lo};
  assign hi_b = {z_hi, y_hi, x_hi};

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
    assign ptrs[g] = {hi_b[g], lo_b[g]};
  end

  logic [AW-1:0] ptr, c_addr, c_wbv;
  logic [1:0]    eff_sel;
  logic          c_wbe, c_code, c_jump, c_r0;

  dag_ptr_mux #(.REG_W(REG_W)) u_mux (
    .ptrs(ptrs), .sel(req_sel), .mode(req_mode), .ptr(ptr), .eff_sel(eff_sel)
  );

  dag_addr_calc #(.REG_W(REG_W), .DISP_W(DISP_W)) u_calc (
    .mode(req_mode), .ptr(ptr), .eff_sel(eff_sel), .disp(req_disp),
    .addr(c_addr), .wb_en(c_wbe), .wb_val(c_wbv),
    .code(c_code), .jump(c_jump), .to_r0(c_r0)
  );

  logic [PKT_W-1:0] pkt_in, pkt_out;
  assign pkt_in = {c_addr, c_wbe, eff_sel, c_wbv, c_code, c_jump, c_r0};

  dag_rsp_stage #(.W(PKT_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pkt_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pkt_out)
  );

  assign {rsp_addr, rsp_wb_en, rsp_wb_sel, rsp_wb_val,
          rsp_code, rsp_jump, rsp_to_r0} = pkt_out;
endmodule

// File: rtl/dag_chk.sv
module dag_chk
  import dag_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int DISP_W = 6,
  localparam int AW = 2 * REG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_mode,
  input logic [1:0]        req_sel,
  input logic [REG_W-1:0]  z_lo,
  input logic [REG_W-1:0]  z_hi,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [AW-1:0]     rsp_addr,
  input logic              rsp_wb_en,
  input logic [AW-1:0]     rsp_wb_val,
  input logic              rsp_code,
  input logic              rsp_jump,
  input logic              rsp_to_r0
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_predec_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_PREDEC |=> rsp_valid && rsp_wb_en && rsp_wb_val == rsp_addr);

  assert_predec_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_PREDEC && req_sel == PSEL_Z |=>
      rsp_addr == $past({z_hi, z_lo}) - AW'(1));

  assert_postinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_POSTINC |=> rsp_valid && rsp_wb_en && rsp_wb_val == rsp_addr + AW'(1));

  assert_wb_only_auto_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode != AM_PREDEC && req_mode != AM_POSTINC |=> rsp_valid && !rsp_wb_en);

  assert_code_from_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_CODE |=>
      rsp_code && rsp_to_r0 && !rsp_jump && rsp_addr == $past({z_hi, z_lo}));

  assert_jump_from_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_JUMP |=>
      rsp_jump && !rsp_code && !rsp_to_r0 && rsp_addr == $past({z_hi, z_lo}));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_wb_val) && $stable(rsp_wb_en));

  assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && (!rsp_valid || rsp_ready) |=> !rsp_valid);
endmodule

bind ptr_addr_gen dag_chk #(.REG_W(REG_W), .DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .req_sel(req_sel), .z_lo(z_lo), .z_hi(z_hi),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_wb_en(rsp_wb_en), .rsp_wb_val(rsp_wb_val), .rsp_code(rsp_code),
  .rsp_jump(rsp_jump), .rsp_to_r0(rsp_to_r0)
);

// File: tb/sim_ptr_addr_gen.sv
module sim_ptr_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic [2:0] req_mode = 0;
  logic [1:0] req_sel = 0;
  logic [5:0] req_disp = 0;
  logic [7:0] x_lo = 0, x_hi = 0, y_lo = 0, y_hi = 0, z_lo = 0, z_hi = 0;
  logic req_ready, rsp_valid, rsp_wb_en, rsp_code, rsp_jump, rsp_to_r0;
  logic [1:0] rsp_wb_sel;
  logic [15:0] rsp_addr, rsp_wb_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen u0 (.*);

  typedef struct {
    logic [15:0] addr; logic wbe; logic [1:0] wsel; logic [15:0] wval;
    logic code; logic jump; logic r0; string tag;
  } exp_t;

  exp_t q[$];
  int errors = 0, checks = 0;
  int ready_ctl = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                                 input logic [15:0] xv, input logic [15:0] yv,
                                 input logic [15:0] zv, input string tag);
    exp_t e;
    logic [1:0] es;
    logic [15:0] p;
    es = (m == 3'd4 || m == 3'd5 || s == 2'd3) ? 2'd2 : s;
    p  = (es == 2'd0) ? xv : (es == 2'd1) ? yv : zv;
    e.addr = p; e.wbe = 0; e.wsel = es; e.wval = p;
    e.code = 0; e.jump = 0; e.r0 = 0; e.tag = tag;
    case (m)
      3'd1: if (es != 2'd0) e.addr = p + {10'd0, d};
      3'd2: begin e.addr = p - 16'd1; e.wval = p - 16'd1; e.wbe = 1; end
      3'd3: begin e.wval = p + 16'd1; e.wbe = 1; end
      3'd4: begin e.code = 1; e.r0 = 1; end
      3'd5: e.jump = 1;
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                      input logic [15:0] xv, input logic [15:0] yv, input logic [15:0] zv,
                      input string tag);
    @(negedge clk);
    req_mode = m; req_sel = s; req_disp = d;
    {x_hi, x_lo} = xv; {y_hi, y_lo} = yv; {z_hi, z_lo} = zv;
    req_valid = 1;
    forever begin
      #1;
      if (req_ready) begin
        q.push_back(model(m, s, d, xv, yv, zv, tag));
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 0;
    while (q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // ready driver
  initial forever begin
    @(negedge clk);
    cyc++;
    rsp_ready = (ready_ctl == 0) ? 1'b1 :
                (ready_ctl == 2) ? 1'b0 : ((cyc % 3) != 0);
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected response", 64'(rsp_addr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_addr == e.addr && rsp_wb_en == e.wbe && rsp_wb_sel == e.wsel &&
            (!e.wbe || rsp_wb_val == e.wval) && rsp_code == e.code &&
            rsp_jump == e.jump && rsp_to_r0 == e.r0, e.tag, "response",
            {rsp_addr, 7'd0, rsp_wb_en, 6'd0, rsp_wb_sel, rsp_wb_val, 5'd0, rsp_code, rsp_jump, rsp_to_r0},
            {e.addr, 7'd0, e.wbe, 6'd0, e.wsel, e.wval, 5'd0, e.code, e.jump, e.r0});
      end
    end
  end

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 0 && req_ready == 1, "R9", "in reset", {rsp_valid, req_ready}, 2'b01);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(rsp_valid == 0 && req_ready == 1, "R9", "idle after reset", {rsp_valid, req_ready}, 2'b01);

    // R1 / R10 / R5: plain indirect on each pointer
    send(3'd0, 2'd0, 6'd5, 16'h1234, 16'hABCD, 16'h0F0F, "R1_R10");
    send(3'd0, 2'd1, 6'd0, 16'h1234, 16'hABCD, 16'h0F0F, "R1");
    send(3'd0, 2'd2, 6'd0, 16'h1234, 16'hABCD, 16'h0F0F, "R5");
    // R2: displacement
    send(3'd1, 2'd1, 6'h10, 16'h0000, 16'h2000, 16'h3000, "R2");
    send(3'd1, 2'd2, 6'h20, 16'h0000, 16'h2000, 16'h3000, "R2");
    send(3'd1, 2'd1, 6'd63, 16'h0000, 16'hFFF0, 16'h3000, "R2_wrap");
    send(3'd1, 2'd0, 6'd63, 16'h4444, 16'h2000, 16'h3000, "R2_x_ignored");
    // R3: pre-decrement
    send(3'd2, 2'd2, 6'd0, 16'h0000, 16'h0000, 16'h0000, "R3_wrap");
    send(3'd2, 2'd0, 6'd9, 16'h1000, 16'h0000, 16'h0000, "R3");
    // R4: post-increment
    send(3'd3, 2'd1, 6'd0, 16'h0000, 16'hFFFF, 16'h0000, "R4_wrap");
    send(3'd3, 2'd0, 6'd0, 16'h00FF, 16'h0000, 16'h0000, "R4");
    // R6 / R7: Z forced
    send(3'd4, 2'd0, 6'd0, 16'h1111, 16'h2222, 16'h3456, "R6");
    send(3'd5, 2'd1, 6'd0, 16'h1111, 16'h2222, 16'h789A, "R7");
    // R11: reserved codes
    send(3'd6, 2'd1, 6'd7, 16'h1111, 16'h2222, 16'h3333, "R11");
    send(3'd7, 2'd0, 6'd7, 16'h1111, 16'h2222, 16'h3333, "R11");
    send(3'd3, 2'd3, 6'd0, 16'h1111, 16'h2222, 16'h3333, "R11_sel3");
    drain();

    // R8: stall holds output and blocks requests
    ready_ctl = 2;
    @(negedge clk);
    send(3'd1, 2'd2, 6'd4, 16'h0, 16'h0, 16'h5000, "R8_stall");
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      #3;
      chk(rsp_valid == 1 && req_ready == 0 && rsp_addr == 16'h5004, "R8", "hold",
          {rsp_valid, req_ready, rsp_addr}, {2'b10, 16'h5004});
      @(negedge clk);
    end
    ready_ctl = 0;
    drain();

    // R8: stream under irregular ready
    ready_ctl = 1;
    for (int k = 0; k < 24; k++)
      send(3'(k % 6), 2'(k % 3), 6'(k * 5), 16'(k * 16'h0101), 16'(16'hFF00 + k), 16'(k * 16'h0777), "R8_stream");
    drain();
    ready_ctl = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule